// File: doc/BRIEF.md
# Dual Serial Bit-Stream Word Assembler

This block turns two one-bit serial streams, one carrying in-phase (I) samples and one carrying quadrature (Q) samples, into pairs of 16-bit words. It derives its own bit clock from the system clock and drives it out on a pin so that the sender can shift data to it. On every active edge of that bit clock, one new bit is taken from each stream in lockstep. The bits arrive most significant bit first.

A transmit-enable input marks frames and gates capture. The first active bit-clock edge on which enable is true, after it has been false, carries bit 15 of both words. Once the sixteenth bit has been taken, the block presents both words together with a one-cycle valid strobe on the system clock. If enable stays true, the next frame begins on the very next active edge. If enable falls before a frame is complete, the bits gathered so far are thrown away.

Three static configuration inputs set the behaviour. One picks which bit-clock edge is active. One inverts the sense of the enable pin. One chooses whether the output words keep their last value or are forced to zero while enable is false.

Top module: `serial_pair_deser`

## Requirements
- R1: After reset the bit clock output is 0. It then toggles every DIV_HALF system clock cycles, with DIV_HALF defaulting to 2.
- R2: With cfg_edge_inv = 0 a bit is taken on the system clock edge that drives bclk_o from 0 to 1. With cfg_edge_inv = 1 it is taken on the edge that drives bclk_o from 1 to 0.
- R3: Enable is true when tx_en differs from cfg_en_inv. That means tx_en high when cfg_en_inv = 0, and tx_en low when cfg_en_inv = 1.
- R4: Each captured bit enters both words at bit 0 and shifts toward bit 15, so the first bit of a frame lands in bit 15 (MSB first). ser_i feeds word_i_o and ser_q feeds word_q_o.
- R5: The first capture edge with enable true after a capture edge with enable false is bit 15 of a new frame.
- R6: On the capture edge of the sixteenth bit, word_i_o and word_q_o take the assembled words and word_vld_o is high for exactly one system clock cycle. While enable is true, the output words change at no other time.
- R7: If enable stays true after a frame completes, the next capture edge is bit 15 of the following frame, with no idle bit in between.
- R8: A capture edge with enable false discards any partial frame. No valid strobe is produced for it, and the next frame starts again at bit 15.
- R9: On a capture edge with enable false, the serial inputs are ignored. With cfg_hold_last = 1 the output words keep their value. With cfg_hold_last = 0 both output words become zero.
- R10: While rst_n is low, bclk_o, word_vld_o, word_i_o and word_q_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_edge_inv | input | 1 | 0: rising bit-clock edge is active, 1: falling edge |
| cfg_en_inv | input | 1 | Inverts the sense of tx_en |
| cfg_hold_last | input | 1 | 1: hold output words while disabled, 0: force them to zero |
| tx_en | input | 1 | Transmit enable: frame alignment and capture gate |
| ser_i | input | 1 | Serial I stream, MSB first |
| ser_q | input | 1 | Serial Q stream, MSB first |
| bclk_o | output | 1 | Generated bit clock |
| word_i_o | output | 16 | Assembled I word |
| word_q_o | output | 16 | Assembled Q word |
| word_vld_o | output | 1 | One-cycle strobe when a complete frame is presented |

## Verification
Each frame uses different I and Q values, including 0x8001 against 0x7FFE, which are bit-wise complements of each other. With these values, any swap of the two lanes, any reversal of bit order, or any misalignment by one bit shows up as a wrong word. A single frame that starts after an idle gap tests frame start. Two frames sent back to back with enable held true test wrap-around without a gap. A short burst that is cut off and then followed by a full frame tests that partial frames are discarded, because leftover bits would corrupt the following word. The same traffic is repeated with the falling edge active, the enable pin inverted and the zero-on-disable setting. This separates the two capture edges, the two enable polarities, and hold versus zero.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int NUM_LANES = 2;

    typedef enum int {
        LANE_I = 0,
        LANE_Q = 1
    } lane_e;

    function automatic logic en_level(input logic pin, input logic inv);
        return pin ^ inv;
    endfunction

endpackage

// File: rtl/spd_bclk_gen.sv
module spd_bclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_inv,
    output logic bclk,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    term;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt == CW'(DIV_HALF - 1));
        tick = term && (st_q.lvl == edge_inv);
        if (term) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk = st_q.lvl;
endmodule

// File: rtl/spd_frame_ctrl.sv
module spd_frame_ctrl #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    output logic capture,
    output logic flush,
    output logic frame_done
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        capture    = tick && en;
        flush      = tick && !en;
        frame_done = capture && (cnt_q == CNT_W'(WORD_W - 1));
        cnt_d      = cnt_q;
        if (flush)           cnt_d = '0;
        else if (frame_done) cnt_d = '0;
        else if (capture)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spd_lane_shift.sv
module spd_lane_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              flush,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-2:0] sh_d, sh_q;

    always_comb begin
        word_next = {sh_q, bit_in};
        sh_d      = sh_q;
        if (flush)        sh_d = '0;
        else if (capture) sh_d = word_next[WORD_W-2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/serial_pair_deser.sv
module serial_pair_deser #(
    parameter int DIV_HALF = 2,
    parameter int WORD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_edge_inv,
    input  logic              cfg_en_inv,
    input  logic              cfg_hold_last,
    input  logic              tx_en,
    input  logic              ser_i,
    input  logic              ser_q,
    output logic              bclk_o,
    output logic [WORD_W-1:0] word_i_o,
    output logic [WORD_W-1:0] word_q_o,
    output logic              word_vld_o
);
    import spd_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] wi;
        logic [WORD_W-1:0] wq;
        logic              vld;
    } out_st_t;

    logic              bit_tick;
    logic              en_true;
    logic              capture, flush, frame_done;
    logic              lane_bit  [NUM_LANES];
    logic [WORD_W-1:0] lane_word [NUM_LANES];
    out_st_t           o_d, o_q;

    assign en_true           = en_level(tx_en, cfg_en_inv);
    assign lane_bit[LANE_I]  = ser_i;
    assign lane_bit[LANE_Q]  = ser_q;

    spd_bclk_gen #(.DIV_HALF(DIV_HALF)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_inv (cfg_edge_inv),
        .bclk     (bclk_o),
        .tick     (bit_tick)
    );

    spd_frame_ctrl #(.WORD_W(WORD_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .en         (en_true),
        .capture    (capture),
        .flush      (flush),
        .frame_done (frame_done)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        spd_lane_shift #(.WORD_W(WORD_W)) u_shift (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture   (capture),
            .flush     (flush),
            .bit_in    (lane_bit[g]),
            .word_next (lane_word[g])
        );
    end

    always_comb begin
        o_d     = o_q;
        o_d.vld = 1'b0;
        if (frame_done) begin
            o_d.wi  = lane_word[LANE_I];
            o_d.wq  = lane_word[LANE_Q];
            o_d.vld = 1'b1;
        end else if (flush && !cfg_hold_last) begin
            o_d.wi = '0;
            o_d.wq = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign word_i_o   = o_q.wi;
    assign word_q_o   = o_q.wq;
    assign word_vld_o = o_q.vld;
endmodule

// File: rtl/serial_pair_deser_chk.sv
module serial_pair_deser_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_edge_inv,
    input logic              cfg_en_inv,
    input logic              cfg_hold_last,
    input logic              tx_en,
    input logic              bclk_o,
    input logic              bit_tick,
    input logic [WORD_W-1:0] word_i_o,
    input logic [WORD_W-1:0] word_q_o,
    input logic              word_vld_o
);
    // R6
    vld_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R2
    bclk_active_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> (bclk_o == !cfg_edge_inv));

    // R3
    vld_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(tx_en ^ cfg_en_inv));

    // R9
    hold_keeps_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hold_last && !word_vld_o) |-> ($stable(word_i_o) && $stable(word_q_o)));

    // R9
    disable_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hold_last && $past(bit_tick && !(tx_en ^ cfg_en_inv)))
            |-> (word_i_o == '0 && word_q_o == '0));

    // R6
    words_change_only_on_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_i_o) |-> (word_vld_o || (!cfg_hold_last && word_i_o == '0)));
endmodule

bind serial_pair_deser serial_pair_deser_chk #(.WORD_W(WORD_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_edge_inv  (cfg_edge_inv),
    .cfg_en_inv    (cfg_en_inv),
    .cfg_hold_last (cfg_hold_last),
    .tx_en         (tx_en),
    .bclk_o        (bclk_o),
    .bit_tick      (bit_tick),
    .word_i_o      (word_i_o),
    .word_q_o      (word_q_o),
    .word_vld_o    (word_vld_o)
);

// File: tb/serial_pair_deser_tb.sv
module serial_pair_deser_tb_top;
    localparam int DH = 2;
    localparam int W  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_edge_inv = 1'b0, cfg_en_inv = 1'b0, cfg_hold_last = 1'b1;
    logic         tx_en = 1'b0, ser_i = 1'b0, ser_q = 1'b0;
    logic         bclk_o, word_vld_o;
    logic [W-1:0] word_i_o, word_q_o;

    int checks = 0, failures = 0, vld_seen = 0;
    bit finished = 0;

    // behavioural reference state
    int           k_m = 0, cnt_m = 0;
    logic         bclk_m = 1'b0, vld_m = 1'b0;
    logic [W-1:0] shi_m = '0, shq_m = '0, oi_m = '0, oq_m = '0;

    always #10 clk = ~clk;

    serial_pair_deser #(.DIV_HALF(DH), .WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_edge_inv(cfg_edge_inv), .cfg_en_inv(cfg_en_inv),
        .cfg_hold_last(cfg_hold_last), .tx_en(tx_en), .ser_i(ser_i), .ser_q(ser_q),
        .bclk_o(bclk_o), .word_i_o(word_i_o), .word_q_o(word_q_o), .word_vld_o(word_vld_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            k_m <= 0; cnt_m <= 0; bclk_m <= 1'b0; vld_m <= 1'b0;
            shi_m <= '0; shq_m <= '0; oi_m <= '0; oq_m <= '0;
        end else begin
            bit term, tk;
            term = ((k_m % DH) == DH - 1);
            tk   = term && (bclk_m == cfg_edge_inv);
            k_m  <= k_m + 1;
            if (term) bclk_m <= ~bclk_m;
            vld_m <= 1'b0;
            if (tk) begin
                if (tx_en != cfg_en_inv) begin
                    shi_m <= {shi_m[W-2:0], ser_i};
                    shq_m <= {shq_m[W-2:0], ser_q};
                    if (cnt_m == W - 1) begin
                        oi_m  <= {shi_m[W-2:0], ser_i};
                        oq_m  <= {shq_m[W-2:0], ser_q};
                        vld_m <= 1'b1;
                        cnt_m <= 0;
                    end else begin
                        cnt_m <= cnt_m + 1;
                    end
                end else begin
                    cnt_m <= 0; shi_m <= '0; shq_m <= '0;
                    if (!cfg_hold_last) begin oi_m <= '0; oq_m <= '0; end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 bclk_o", W'(bclk_o), W'(bclk_m));
            chk("R6 word_vld_o", W'(word_vld_o), W'(vld_m));
            chk("R4 word_i_o", word_i_o, oi_m);
            chk("R4 word_q_o", word_q_o, oq_m);
            if (word_vld_o) vld_seen++;
        end
    end

    function automatic bit tick_next();
        return rst_n && ((k_m % DH) == DH - 1) && (bclk_m == cfg_edge_inv);
    endfunction

    task automatic put_bit(input logic en, input logic bi, input logic bq);
        while (!tick_next()) @(negedge clk);
        tx_en = en ^ cfg_en_inv;
        ser_i = bi;
        ser_q = bq;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b, input int nbits);
        for (int j = 0; j < nbits; j++) put_bit(1'b1, a[W-1-j], b[W-1-j]);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) put_bit(1'b0, j[0], ~j[0]);
    endtask

    task automatic do_reset(input logic ei, input logic eninv, input logic hold);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_edge_inv = ei; cfg_en_inv = eninv; cfg_hold_last = hold;
        tx_en = eninv; ser_i = 1'b0; ser_q = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 bclk_o in reset", W'(bclk_o), '0);
        chk("R10 word_vld_o in reset", W'(word_vld_o), '0);
        chk("R10 word_i_o in reset", word_i_o, '0);
        chk("R10 word_q_o in reset", word_q_o, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        int v0;
        // rising edge, enable active high, hold last
        do_reset(1'b0, 1'b0, 1'b1);
        idle(2);
        send_word(16'hA5C3, 16'h3C5A, 16);
        chk("R5 R6 frame I after idle", word_i_o, 16'hA5C3);
        chk("R5 R6 frame Q after idle", word_q_o, 16'h3C5A);
        chk("R6 valid with frame", W'(word_vld_o), 16'h0001);
        idle(5);
        chk("R9 hold I while disabled", word_i_o, 16'hA5C3);
        chk("R9 hold Q while disabled", word_q_o, 16'h3C5A);

        // R7 back-to-back frames
        send_word(16'h1234, 16'hFEDC, 16);
        chk("R7 first frame I", word_i_o, 16'h1234);
        send_word(16'h8001, 16'h7FFE, 16);
        chk("R7 gapless second frame I", word_i_o, 16'h8001);
        chk("R7 gapless second frame Q", word_q_o, 16'h7FFE);

        // R8 partial frame discarded
        idle(1);
        v0 = vld_seen;
        send_word(16'hFFFF, 16'hFFFF, 7);
        idle(2);
        chk("R8 no valid for partial frame", W'(vld_seen - v0), '0);
        chk("R8 words untouched by partial", word_i_o, 16'h8001);
        send_word(16'h0F0F, 16'hF0F0, 16);
        chk("R8 restart I after partial", word_i_o, 16'h0F0F);
        chk("R8 restart Q after partial", word_q_o, 16'hF0F0);

        // R2 falling edge, R3 inverted enable, R9 zero on disable
        do_reset(1'b1, 1'b1, 1'b0);
        idle(3);
        chk("R3 inverted enable, pin high ignored", word_i_o, '0);
        send_word(16'hC0DE, 16'hBEEF, 16);
        chk("R2 R3 falling-edge frame I", word_i_o, 16'hC0DE);
        chk("R2 R3 falling-edge frame Q", word_q_o, 16'hBEEF);
        idle(1);
        chk("R9 zero I on disable", word_i_o, '0);
        chk("R9 zero Q on disable", word_q_o, '0);
        send_word(16'h5555, 16'hAAAA, 16);
        send_word(16'h0001, 16'h8000, 16);
        chk("R4 MSB-first I", word_i_o, 16'h0001);
        chk("R4 MSB-first Q", word_q_o, 16'h8000);
        idle(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule